// File: doc/BRIEF.md
# External Bus Read Recovery Inserter

This block sits between the sequencer that issues external bus accesses and a memory bus with four chip-select channels. Each channel has a small recovery count. When a read on the bus is followed by a write, or by a read to another channel, the block holds off the new access until that many dead cycles have passed. This keeps a slow device that is still driving the data lines from clashing with the next transfer. Back-to-back reads to the same channel go straight through. A write followed by any access never waits, and neither does the first access after reset.

The count applied is always the one belonging to the channel of the preceding read. Every cycle that passes after that read counts against the requirement, whether the cycle is idle or stalled. One channel can be marked as SDRAM through static inputs, and reads on that channel never demand recovery. Software reaches the counts through a simple write port and a combinational read port. A write is refused while the target channel is enabled.

An access is taken in the cycle where `reqValid` is high and `stall` is low. The sequencer keeps its request steady while `stall` is high.

Top module: `readRecoveryGate`

## Requirements
- R1: Each channel's recovery count is a 4-bit field held at bits 19:16 of its configuration word. A value N asks for N dead cycles (0 to 15), and every count resets to 0.
- R2: Reading a configuration word always returns zero in bits 31:20 and 15:0, whatever was written there.
- R3: A configuration write to a channel whose `chanEnable` bit is 1 leaves its count unchanged. With the bit at 0, the write takes effect in the next cycle.
- R4: After a taken read, a write to any channel, including the same one, requested in the following cycle is stalled for exactly N cycles. N is the count of the read's channel.
- R5: After a taken read, a read to a different channel requested in the following cycle is stalled for exactly N cycles. N is the count of the earlier read's channel, not the new one.
- R6: A read to the same channel as the immediately preceding taken read is never stalled.
- R7: When k cycles pass with no request between a taken read and the next request, the stall lasts max(N-k, 0) cycles.
- R8: A read to the channel selected by `sdramChan` while `sdramOn` is 1 demands zero recovery cycles, whatever count is programmed for it.
- R9: An access that follows a taken write is never stalled, and neither is the first access after reset.
- R10: `stall` is high only while `reqValid` is high. It rises in the same cycle as the request, without a register in the path, and stays high without a break until the remaining count is exhausted. The access is then taken in the first cycle with `stall` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgChan | input | 2 | Channel addressed by the configuration write |
| cfgWdata | input | 32 | Configuration write data; the count is taken from bits 19:16 |
| cfgRdChan | input | 2 | Channel selected for configuration readback |
| cfgRdata | output | 32 | Configuration word of `cfgRdChan` (combinational) |
| chanEnable | input | 4 | Per-channel enable bits; a set bit blocks configuration writes |
| sdramChan | input | 2 | Channel that is treated as SDRAM |
| sdramOn | input | 1 | Enables the SDRAM marking of `sdramChan` |
| reqValid | input | 1 | Access request from the sequencer |
| reqWrite | input | 1 | Request type: 1 write, 0 read |
| reqChan | input | 2 | Target channel of the request |
| stall | output | 1 | Holds off the requested access |

## Verification
`stall` is combinational. The bench therefore raises a request at a falling edge, reads `stall` one time step later in the same cycle, and counts the falling edges at which it is still high until the access is taken at the next rising edge. A read taken at rising edge P loads its budget in that same edge, so a request placed in the cycle right after P expects exactly N stalled cycles. Each idle falling edge inserted before the request lowers the expected count by one. Configuration writes land at the rising edge after the strobe, and readback is combinational, so each readback is sampled at the falling edge after the write strobe is dropped.

// File: rtl/recoveryPkg.sv
package recoveryPkg;
  // Strobes sent from the control module to the datapath each cycle.
  typedef struct packed {
    logic loadRead;     // a read is taken: load the channel budget, remember the channel
    logic clearRemain;  // a write is taken: no recovery is owed afterwards
    logic decRemain;    // no access taken: one more dead cycle has passed
  } strobeT;
endpackage

// File: rtl/recoveryDatapath.sv
module recoveryDatapath
  import recoveryPkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 32,
  parameter int FIELD_LSB = 16,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgChan,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic [CH_W-1:0]   cfgRdChan,
  output logic [DATA_W-1:0] cfgRdata,
  input  logic [NUM_CH-1:0] chanEnable,
  input  logic [CH_W-1:0]   sdramChan,
  input  logic              sdramOn,
  input  logic [CH_W-1:0]   reqChan,
  input  strobeT            strobe,
  output logic [CH_W-1:0]   lastChan,
  output logic              remainZero
);

  logic [CNT_W-1:0] rcvCount [NUM_CH];
  logic [CNT_W-1:0] effCount;
  logic [CNT_W-1:0] remain;

  // Per-channel count registers; a write is refused while the channel is enabled.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic wrHit;
    assign wrHit = cfgWe && (cfgChan == CH_W'(ch)) && !chanEnable[ch];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rcvCount[ch] <= '0;
      end else if (wrHit) begin
        rcvCount[ch] <= cfgWdata[FIELD_LSB +: CNT_W];
      end
    end
  end

  // Combinational readback; every bit outside the count field reads as zero.
  always_comb begin
    cfgRdata = '0;
    cfgRdata[FIELD_LSB +: CNT_W] = rcvCount[cfgRdChan];
  end

  // Budget owed after a read on the requested channel (zero on the SDRAM channel).
  always_comb begin
    if (sdramOn && (reqChan == sdramChan)) begin
      effCount = '0;
    end else begin
      effCount = rcvCount[reqChan];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain   <= '0;
      lastChan <= '0;
    end else begin
      if (strobe.loadRead) begin
        remain   <= effCount;
        lastChan <= reqChan;
      end else if (strobe.clearRemain) begin
        remain <= '0;
      end else if (strobe.decRemain && (remain != '0)) begin
        remain <= remain - 1'b1;
      end
    end
  end

  assign remainZero = (remain == '0);

endmodule

// File: rtl/recoveryControl.sv
module recoveryControl
  import recoveryPkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [CH_W-1:0] reqChan,
  input  logic [CH_W-1:0] lastChan,
  input  logic            remainZero,
  output logic            stall,
  output strobeT          strobe
);

  logic lastRead;  // most recent taken access was a read
  logic needGap;
  logic accept;

  assign needGap = lastRead && (reqWrite || (reqChan != lastChan));
  assign stall   = reqValid && needGap && !remainZero;
  assign accept  = reqValid && !stall;

  always_comb begin
    strobe             = '0;
    strobe.loadRead    = accept && !reqWrite;
    strobe.clearRemain = accept && reqWrite;
    strobe.decRemain   = !accept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastRead <= 1'b0;
    end else if (accept) begin
      lastRead <= !reqWrite;
    end
  end

endmodule

// File: rtl/readRecoveryGate.sv
module readRecoveryGate
  import recoveryPkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 32,
  parameter int FIELD_LSB = 16,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgChan,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic [CH_W-1:0]   cfgRdChan,
  output logic [DATA_W-1:0] cfgRdata,
  input  logic [NUM_CH-1:0] chanEnable,
  input  logic [CH_W-1:0]   sdramChan,
  input  logic              sdramOn,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [CH_W-1:0]   reqChan,
  output logic              stall
);

  strobeT          strobe;
  logic [CH_W-1:0] lastChan;
  logic            remainZero;

  recoveryControl #(.NUM_CH(NUM_CH)) i_control (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqChan    (reqChan),
    .lastChan   (lastChan),
    .remainZero (remainZero),
    .stall      (stall),
    .strobe     (strobe)
  );

  recoveryDatapath #(
    .NUM_CH    (NUM_CH),
    .CNT_W     (CNT_W),
    .DATA_W    (DATA_W),
    .FIELD_LSB (FIELD_LSB)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgChan    (cfgChan),
    .cfgWdata   (cfgWdata),
    .cfgRdChan  (cfgRdChan),
    .cfgRdata   (cfgRdata),
    .chanEnable (chanEnable),
    .sdramChan  (sdramChan),
    .sdramOn    (sdramOn),
    .reqChan    (reqChan),
    .strobe     (strobe),
    .lastChan   (lastChan),
    .remainZero (remainZero)
  );

endmodule

// File: rtl/recoveryChecker.sv
module recoveryChecker #(
  parameter int NUM_CH    = 4,
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 32,
  parameter int FIELD_LSB = 16,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int MAX_RUN  = (1 << CNT_W) - 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [CH_W-1:0]   cfgChan,
  input logic [CH_W-1:0]   cfgRdChan,
  input logic [DATA_W-1:0] cfgRdata,
  input logic [NUM_CH-1:0] chanEnable,
  input logic [CH_W-1:0]   sdramChan,
  input logic              sdramOn,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [CH_W-1:0]   reqChan,
  input logic              stall
);

  localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(((1 << CNT_W) - 1) << FIELD_LSB);

  logic takenRead;
  logic takenWrite;
  logic [CNT_W:0] stallRun;

  assign takenRead  = reqValid && !stall && !reqWrite;
  assign takenWrite = reqValid && !stall && reqWrite;

  // Length of the current unbroken stall, counted in the checker.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stallRun <= '0;
    end else if (stall) begin
      stallRun <= stallRun + 1'b1;
    end else begin
      stallRun <= '0;
    end
  end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata & ~FIELD_MASK) == '0);

  p_guarded_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && chanEnable[cfgChan])
      |=> (cfgRdChan != $past(cfgRdChan) || cfgRdata == $past(cfgRdata)));

  p_same_chan_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    takenRead |=> !(reqValid && !reqWrite && reqChan == $past(reqChan) && stall));

  p_sdram_no_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (takenRead && sdramOn && reqChan == sdramChan) |=> !stall);

  p_after_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    takenWrite |=> !stall);

  p_stall_needs_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> reqValid);

  p_bounded_stall_r1: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (stallRun < MAX_RUN));

endmodule

bind readRecoveryGate recoveryChecker #(
  .NUM_CH    (NUM_CH),
  .CNT_W     (CNT_W),
  .DATA_W    (DATA_W),
  .FIELD_LSB (FIELD_LSB)
) i_recoveryChecker (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWe      (cfgWe),
  .cfgChan    (cfgChan),
  .cfgRdChan  (cfgRdChan),
  .cfgRdata   (cfgRdata),
  .chanEnable (chanEnable),
  .sdramChan  (sdramChan),
  .sdramOn    (sdramOn),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .reqChan    (reqChan),
  .stall      (stall)
);

// File: tb/test_readRecoveryGate.sv
`timescale 1ns/1ps
module test_readRecoveryGate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgChan = '0;
  logic [31:0] cfgWdata = '0;
  logic [1:0]  cfgRdChan = '0;
  logic [31:0] cfgRdata;
  logic [3:0]  chanEnable = '0;
  logic [1:0]  sdramChan = 2'd3;
  logic        sdramOn = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqChan = '0;
  logic        stall;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  readRecoveryGate i_readRecoveryGate (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgChan(cfgChan), .cfgWdata(cfgWdata),
    .cfgRdChan(cfgRdChan), .cfgRdata(cfgRdata), .chanEnable(chanEnable),
    .sdramChan(sdramChan), .sdramOn(sdramOn), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqChan(reqChan), .stall(stall)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; leaves at a falling edge.
  task automatic cfgWrite(input logic [1:0] ch, input logic [31:0] data);
    cfgWe = 1'b1; cfgChan = ch; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgRead(input logic [1:0] ch, output logic [31:0] data);
    cfgRdChan = ch;
    #1;
    data = cfgRdata;
  endtask

  // Raise a request, count stalled cycles, return once it is taken.
  task automatic access(input bit wr, input logic [1:0] ch, output int st);
    st = 0;
    reqValid = 1'b1; reqWrite = wr; reqChan = ch;
    #1;
    while (stall) begin
      st++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    int st;
    for (int ch = 0; ch < 4; ch++) begin
      cfgRead(2'(ch), d);
      check("R1 reset count", d, 0);
    end
    access(1'b0, 2'd2, st);
    check("R9 first access after reset", st, 0);
    access(1'b0, 2'd1, st);
    check("R5 cross read with zero count", st, 0);
  endtask

  task automatic testConfig();
    logic [31:0] d;
    cfgWrite(2'd1, 32'hFFF5_FFFF);
    cfgRead(2'd1, d);
    check("R2 reserved bits zero", d, 32'h0005_0000);
    cfgWrite(2'd2, 32'h0002_0000);
    cfgRead(2'd2, d);
    check("R1 count field", d, 32'h0002_0000);
  endtask

  task automatic testGuard();
    logic [31:0] d;
    chanEnable = 4'b0010;
    cfgWrite(2'd1, 32'h0009_0000);
    cfgRead(2'd1, d);
    check("R3 write ignored while enabled", d, 32'h0005_0000);
    chanEnable = 4'b0000;
    cfgWrite(2'd1, 32'h0009_0000);
    cfgRead(2'd1, d);
    check("R3 write accepted while disabled", d, 32'h0009_0000);
    cfgWrite(2'd1, 32'h0005_0000);
  endtask

  task automatic testReadWrite();
    int st;
    access(1'b0, 2'd1, st);
    access(1'b1, 2'd1, st);
    check("R4 read then write same channel", st, 5);
    access(1'b0, 2'd1, st);
    access(1'b1, 2'd0, st);
    check("R4 read then write other channel", st, 5);
  endtask

  task automatic testCrossRead();
    int st;
    access(1'b0, 2'd1, st);
    access(1'b0, 2'd2, st);
    check("R5 cross read uses earlier channel count", st, 5);
    access(1'b0, 2'd1, st);
    check("R5 cross read back uses channel 2 count", st, 2);
  endtask

  task automatic testSameRead();
    int st;
    access(1'b0, 2'd1, st);
    access(1'b0, 2'd1, st);
    check("R6 same channel read", st, 0);
  endtask

  task automatic testIdleCredit();
    int st;
    access(1'b0, 2'd1, st);
    idle(2);
    access(1'b1, 2'd1, st);
    check("R7 two idle cycles credited", st, 3);
    access(1'b0, 2'd1, st);
    idle(7);
    access(1'b0, 2'd3, st);
    check("R7 credit saturates at zero", st, 0);
  endtask

  task automatic testSdram();
    int st;
    cfgWrite(2'd3, 32'h000C_0000);
    access(1'b0, 2'd3, st);
    access(1'b1, 2'd3, st);
    check("R4 channel 3 as plain channel", st, 12);
    sdramOn = 1'b1;
    access(1'b0, 2'd3, st);
    access(1'b1, 2'd3, st);
    check("R8 SDRAM channel needs no gap", st, 0);
    access(1'b0, 2'd3, st);
    access(1'b0, 2'd0, st);
    check("R8 SDRAM read then cross read", st, 0);
    sdramOn = 1'b0;
  endtask

  task automatic testAfterWrite();
    int st;
    access(1'b1, 2'd1, st);
    access(1'b0, 2'd2, st);
    check("R9 write then cross read", st, 0);
    access(1'b1, 2'd2, st);
    access(1'b1, 2'd0, st);
    check("R9 write then write", st, 0);
  endtask

  task automatic testMaxAndStall();
    int st;
    cfgWrite(2'd0, 32'h000F_0000);
    access(1'b0, 2'd0, st);
    access(1'b0, 2'd1, st);
    check("R1 maximum count", st, 15);
    check("R10 no stall without request", stall, 0);
    access(1'b0, 2'd0, st);
    reqValid = 1'b1; reqWrite = 1'b1; reqChan = 2'd0;
    #1;
    check("R10 stall high in request cycle", stall, 1);
    reqValid = 1'b0;
    #1;
    check("R10 stall drops with request", stall, 0);
    @(negedge clk);
    access(1'b1, 2'd0, st);
    check("R10 stall held then released", st, 14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 stall low after reset", stall, 0);
    testReset();
    testConfig();
    testGuard();
    testReadWrite();
    testCrossRead();
    testSameRead();
    testIdleCredit();
    testSdram();
    testAfterWrite();
    testMaxAndStall();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule